// File: doc/BRIEF.md
# Prescaled Compare Timer with Source Select

This block is a general-purpose timer built around a free-running 32-bit up-counter. The count clock is picked from several tick sources: a fast tick, the fast tick divided by four, an external tick, or a slow (32 kHz class) tick. The source can also be set to "none". All sources arrive as single-cycle enable pulses in the block's own clock domain. An 11-bit prescaler thins the selected source before it reaches the counter. When the counter meets the compare value, it restarts from zero and sets a sticky event flag. The event can raise an interrupt and can invert a toggle pin. A capture register samples the counter on a rising edge of a capture input.

Software reaches the block through a plain register port: a byte address, a write strobe with write data, and combinational read data. The port has no valid/ready handshake and no back-pressure. A write takes effect at the clock edge on which the strobe is high, and every read completes in the same cycle. The tick, capture, toggle and interrupt pins are plain level or pulse signals.

Top module: `pscmp_timer`

## Requirements
- R1: After rst_n is low, the registers at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 all read 0, and tog_out and irq are 0.
- R2: Register map: 0x00 control, 0x04 prescale, 0x08 compare, 0x0C capture, 0x10 counter, 0x14 status. Writes to capture and counter have no effect. Any other address reads 0. In control, only bits 0, 3:1, 4, 9, 10 and 15 are kept, and all other bits read 0.
- R3: Control bits 3:1 pick the tick source: 0 none (the counter holds), 1 fast tick, 2 fast tick divided by four, 3 external tick, 4 slow tick. Codes 5 to 7 behave as none.
- R4: With code 2, one source pulse is produced on every fourth fast tick after the code is selected with the timer running.
- R5: With prescale value P (bits 10:0 at 0x04), the counter advances once per P+1 selected source pulses. If P is lowered below the current phase, the next source pulse advances the counter.
- R6: When the counter advances while it equals the compare value C, it becomes 0 instead and status bit 0 is set. Events therefore repeat every C+1 advances.
- R7: With control bit 9 set, tog_out inverts on every compare event. With bit 9 clear, it holds.
- R8: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. If an event occurs in the same cycle as the clear, the flag stays set.
- R9: irq equals status bit 0 AND control bit 4.
- R10: With control bit 10 set, a 0-to-1 transition of cap_in copies the counter value of that cycle (before its update) into capture. With bit 10 clear, capture holds.
- R11: A control write with bit 15 set returns control, prescale, compare, capture, counter, status and tog_out to reset values at that edge. Control reads 0x00008000 for the next cycle only, then bit 15 reads 0.
- R12: With control bit 0 clear, the counter holds its value, and the prescaler and divide-by-four phases return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr, combinational |
| fast_tick | input | 1 | Fast source pulse |
| ext_tick | input | 1 | External source pulse |
| slow_tick | input | 1 | Slow source pulse |
| cap_in | input | 1 | Capture trigger level |
| tog_out | output | 1 | Toggle output |
| irq | output | 1 | Compare interrupt |

## Verification
Every result is due one edge after its stimulus. A tick or a write present before an edge shows up in the counter, status, capture, control or tog_out value right after that edge. Read data and irq are combinational views of those registers, so they change in the same cycle as the register they reflect. The bench drives inputs 2 ns after the falling edge and advances its reference model on the rising edge. It compares read data, irq and tog_out at the next falling edge, which is exactly one register stage later. The software-reset pulse is checked on the two falling edges that follow the write, to catch both its one-cycle visibility and its self-clear.

// File: rtl/pscmp_pkg.sv
package pscmp_pkg;
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_PRE   = 'h04;
  localparam int OFS_CMP   = 'h08;
  localparam int OFS_CAPT  = 'h0C;
  localparam int OFS_COUNT = 'h10;
  localparam int OFS_STAT  = 'h14;

  localparam int CB_RUN  = 0;
  localparam int CB_SRCL = 1;
  localparam int CB_IE   = 4;
  localparam int CB_TOG  = 9;
  localparam int CB_CAP  = 10;
  localparam int CB_SWR  = 15;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_FAST = 3'd1,
    SRC_QTR  = 3'd2,
    SRC_EXT  = 3'd3,
    SRC_SLOW = 3'd4
  } src_e;
endpackage

// File: rtl/pscmp_clksel.sv
module pscmp_clksel
  import pscmp_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       run,
  input  logic [2:0] sel,
  input  logic       fast_tick,
  input  logic       ext_tick,
  input  logic       slow_tick,
  output logic       src_tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] phase;
  logic          div_on;
  logic          qtr_tick;

  assign div_on   = run && (sel == SRC_QTR);
  assign qtr_tick = fast_tick && (phase == PW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase <= '0;
    else if (clr || !div_on)   phase <= '0;
    else if (fast_tick)        phase <= (phase == PW'(DIV - 1)) ? '0 : phase + 1'b1;
  end

  always_comb begin
    case (sel)
      SRC_FAST: src_tick = fast_tick;
      SRC_QTR:  src_tick = qtr_tick;
      SRC_EXT:  src_tick = ext_tick;
      SRC_SLOW: src_tick = slow_tick;
      default:  src_tick = 1'b0;
    endcase
    src_tick = src_tick && run;
  end

  AST_QTR_NEEDS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_QTR && src_tick) |-> fast_tick); // R4
endmodule

// File: rtl/pscmp_prescale.sv
module pscmp_prescale #(
  parameter int PS_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            run,
  input  logic            src_tick,
  input  logic [PS_W-1:0] limit,
  output logic            tick
);
  logic [PS_W-1:0] phase;

  assign tick = run && src_tick && (phase >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             phase <= '0;
    else if (clr || !run)   phase <= '0;
    else if (src_tick)      phase <= tick ? '0 : phase + 1'b1;
  end

  AST_TICK_FROM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> src_tick); // R5
  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr) |=> (phase == '0)); // R5
endmodule

// File: rtl/pscmp_counter.sv
module pscmp_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] cmp_val,
  input  logic          tog_en,
  input  logic          cap_en,
  input  logic          cap_in,
  input  logic          st_clr,
  output logic [CW-1:0] count,
  output logic [CW-1:0] cap_val,
  output logic          status,
  output logic          tog
);
  logic evt;
  logic cap_q;
  logic cap_edge;

  assign evt      = tick && (count == cmp_val);
  assign cap_edge = cap_in && !cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= 1'b0;
    else        cap_q <= cap_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      cap_val <= '0;
      status  <= 1'b0;
      tog     <= 1'b0;
    end else if (clr) begin
      count   <= '0;
      cap_val <= '0;
      status  <= 1'b0;
      tog     <= 1'b0;
    end else begin
      if (evt)       count <= '0;
      else if (tick) count <= count + 1'b1;
      if (evt)         status <= 1'b1;
      else if (st_clr) status <= 1'b0;
      if (evt && tog_en) tog <= ~tog;
      if (cap_edge && cap_en) cap_val <= count;
    end
  end

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !clr) |=> (count == '0)); // R6
  AST_EVENT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !clr) |=> status); // R8
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && tog_en && !clr) |=> (tog != $past(tog))); // R7
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(count)); // R12
  AST_CAPTURE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !clr) |=> $stable(cap_val)); // R10
endmodule

// File: rtl/pscmp_timer.sv
module pscmp_timer
  import pscmp_pkg::*;
#(
  parameter int AW   = 5,
  parameter int DW   = 32,
  parameter int PS_W = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          fast_tick,
  input  logic          ext_tick,
  input  logic          slow_tick,
  input  logic          cap_in,
  output logic          tog_out,
  output logic          irq
);
  logic            run, ie, tog_en, cap_en, swr_q;
  logic [2:0]      src;
  logic [PS_W-1:0] pre;
  logic [DW-1:0]   cmp;
  logic [DW-1:0]   count, cap_val;
  logic            status;
  logic            src_tick, tick;
  logic            wr_ctrl, swr_hit, st_clr;

  assign wr_ctrl = wr_en && (addr == AW'(OFS_CTRL));
  assign swr_hit = wr_ctrl && wr_data[CB_SWR];
  assign st_clr  = wr_en && (addr == AW'(OFS_STAT)) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {run, ie, tog_en, cap_en, swr_q} <= '0;
      src <= '0;
      pre <= '0;
      cmp <= '0;
    end else if (swr_hit) begin
      {run, ie, tog_en, cap_en} <= '0;
      swr_q <= 1'b1;
      src   <= '0;
      pre   <= '0;
      cmp   <= '0;
    end else begin
      swr_q <= 1'b0;
      if (wr_ctrl) begin
        run    <= wr_data[CB_RUN];
        src    <= wr_data[CB_SRCL +: 3];
        ie     <= wr_data[CB_IE];
        tog_en <= wr_data[CB_TOG];
        cap_en <= wr_data[CB_CAP];
      end
      if (wr_en && addr == AW'(OFS_PRE)) pre <= wr_data[PS_W-1:0];
      if (wr_en && addr == AW'(OFS_CMP)) cmp <= wr_data;
    end
  end

  pscmp_clksel #(.DIV(4)) u_sel (
    .clk(clk), .rst_n(rst_n), .clr(swr_hit), .run(run), .sel(src),
    .fast_tick(fast_tick), .ext_tick(ext_tick), .slow_tick(slow_tick),
    .src_tick(src_tick)
  );

  pscmp_prescale #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(swr_hit), .run(run),
    .src_tick(src_tick), .limit(pre), .tick(tick)
  );

  pscmp_counter #(.CW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(swr_hit), .tick(tick), .cmp_val(cmp),
    .tog_en(tog_en), .cap_en(cap_en), .cap_in(cap_in), .st_clr(st_clr),
    .count(count), .cap_val(cap_val), .status(status), .tog(tog_out)
  );

  assign irq = status && ie;

  always_comb begin
    rd_data = '0;
    case (addr)
      AW'(OFS_CTRL): begin
        rd_data[CB_RUN]       = run;
        rd_data[CB_SRCL +: 3] = src;
        rd_data[CB_IE]        = ie;
        rd_data[CB_TOG]       = tog_en;
        rd_data[CB_CAP]       = cap_en;
        rd_data[CB_SWR]       = swr_q;
      end
      AW'(OFS_PRE):   rd_data[PS_W-1:0] = pre;
      AW'(OFS_CMP):   rd_data = cmp;
      AW'(OFS_CAPT):  rd_data = cap_val;
      AW'(OFS_COUNT): rd_data = count;
      AW'(OFS_STAT):  rd_data[0] = status;
      default:        rd_data = '0;
    endcase
  end

  AST_SWR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    swr_hit |=> (count == '0 && !status && !tog_out && cmp == '0)); // R11
  AST_SWR_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (swr_q && !swr_hit) |=> !swr_q); // R11
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq); // R9
endmodule

// File: tb/pscmp_timer_test.sv
`timescale 1ns/1ps
module pscmp_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = 5'h10;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        fast_tick = 1'b0, ext_tick = 1'b0, slow_tick = 1'b0, cap_in = 1'b0;
  logic        tog_out, irq;

  int checks = 0, fails = 0, cyc = 0;
  int fast_per = 0, ext_per = 0, slow_per = 0;

  always #10 clk = ~clk;

  pscmp_timer uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .fast_tick(fast_tick), .ext_tick(ext_tick),
    .slow_tick(slow_tick), .cap_in(cap_in), .tog_out(tog_out), .irq(irq)
  );

  // behavioural reference model
  bit m_run, m_ie, m_te, m_ce, m_swr, m_st, m_tog, m_cprev;
  int m_src, m_ps, m_div, m_pc;
  bit [31:0] m_cmp, m_cnt, m_cap;

  function automatic bit [31:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return (32'(m_swr) << 15) | (32'(m_ce) << 10) | (32'(m_te) << 9)
                  | (32'(m_ie) << 4) | (32'(m_src) << 1) | 32'(m_run);
      5'h04: return 32'(m_ps);
      5'h08: return m_cmp;
      5'h0C: return m_cap;
      5'h10: return m_cnt;
      5'h14: return 32'(m_st);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    case (a)
      5'h04: return "R5";
      5'h08: return "R6";
      5'h0C: return "R10";
      5'h10: return "R6";
      5'h14: return "R8";
      default: return "R2";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_run, m_ie, m_te, m_ce, m_swr, m_st, m_tog, m_cprev} = '0;
      m_src = 0; m_ps = 0; m_div = 0; m_pc = 0;
      m_cmp = 0; m_cnt = 0; m_cap = 0;
    end else begin
      bit stk, ptk, evt, n_st, n_tog;
      int n_div, n_pc;
      bit [31:0] n_cnt, n_cap;
      case (m_src)
        1: stk = fast_tick;
        2: stk = fast_tick && (m_div == 3);
        3: stk = ext_tick;
        4: stk = slow_tick;
        default: stk = 0;
      endcase
      stk = stk && m_run;
      ptk = stk && (m_pc >= m_ps);
      evt = ptk && (m_cnt == m_cmp);
      n_div = (m_run && m_src == 2) ? (fast_tick ? (m_div + 1) % 4 : m_div) : 0;
      n_pc  = !m_run ? 0 : (stk ? (ptk ? 0 : m_pc + 1) : m_pc);
      n_cnt = evt ? 0 : (ptk ? m_cnt + 1 : m_cnt);
      n_st  = evt ? 1'b1 : ((wr_en && addr == 5'h14 && wr_data[0]) ? 1'b0 : m_st);
      n_tog = (evt && m_te) ? ~m_tog : m_tog;
      n_cap = (cap_in && !m_cprev && m_ce) ? m_cnt : m_cap;
      m_cprev = cap_in;
      m_div = n_div; m_pc = n_pc; m_cnt = n_cnt; m_st = n_st; m_tog = n_tog; m_cap = n_cap;
      m_swr = 0;
      if (wr_en && addr == 5'h04) m_ps = int'(wr_data[10:0]);
      if (wr_en && addr == 5'h08) m_cmp = wr_data;
      if (wr_en && addr == 5'h00) begin
        if (wr_data[15]) begin
          m_swr = 1; {m_run, m_ie, m_te, m_ce} = '0; m_src = 0; m_ps = 0; m_cmp = 0;
          m_cnt = 0; m_cap = 0; m_st = 0; m_tog = 0; m_div = 0; m_pc = 0;
        end else begin
          m_run = wr_data[0]; m_src = int'(wr_data[3:1]); m_ie = wr_data[4];
          m_te = wr_data[9]; m_ce = wr_data[10];
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // per-cycle comparison and tick generation
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(tag_of(addr), rd_data, m_read(addr));
      chk("R9", 32'(irq), 32'(m_st && m_ie));
      chk("R7", 32'(tog_out), 32'(m_tog));
    end
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
    #2;
    fast_tick = (fast_per != 0) && (cyc % fast_per == 0);
    ext_tick  = (ext_per  != 0) && (cyc % ext_per  == 0);
    slow_tick = (slow_per != 0) && (cyc % slow_per == 0);
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); #2;
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); #2;
    wr_en = 1'b0; addr = 5'h10;
  endtask

  task automatic peek(input logic [4:0] a, input string tag, input logic [31:0] exp);
    @(negedge clk); #2; addr = a;
    @(negedge clk); chk(tag, rd_data, exp);
    #2; addr = 5'h10;
  endtask

  task automatic look(input logic [4:0] a, input string tag);
    @(negedge clk); #2; addr = a;
    @(negedge clk); chk(tag, rd_data, m_read(a));
    #2; addr = 5'h10;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cap_pulse();
    @(negedge clk); #2; cap_in = 1'b1;
    @(negedge clk); #2; cap_in = 1'b0;
  endtask

  initial begin
    logic [31:0] snap;
    repeat (4) @(negedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    peek(5'h00, "R1", 0); peek(5'h04, "R1", 0); peek(5'h08, "R1", 0);
    peek(5'h0C, "R1", 0); peek(5'h10, "R1", 0); peek(5'h14, "R1", 0);
    chk("R1", {30'b0, tog_out, irq}, 0);

    // R6 R7 R9 fast source, compare 5, toggle and irq on
    fast_per = 1;
    wr(5'h08, 5);
    wr(5'h00, 32'h0000_0213);
    wait_n(40);
    look(5'h14, "R6");
    chk("R9", 32'(irq), 32'(m_st && m_ie));
    // R8 write-one-to-clear
    wr(5'h14, 0); look(5'h14, "R8");
    wr(5'h14, 1); look(5'h14, "R8");
    // R2 read-only and unmapped registers, masked control bits
    wr(5'h10, 32'h1234_5678); look(5'h10, "R2");
    wr(5'h0C, 32'hFFFF_FFFF); look(5'h0C, "R2");
    peek(5'h18, "R2", 0); peek(5'h02, "R2", 0);
    wr(5'h00, 32'hFFFF_7BEB); look(5'h00, "R2");
    // R5 prescaler
    wr(5'h00, 32'h0000_0213);
    wr(5'h04, 3); wait_n(50); look(5'h10, "R5");
    // R4 divide by four
    wr(5'h04, 0); wr(5'h08, 2);
    wr(5'h00, 32'h0000_0205); wait_n(60); look(5'h10, "R4");
    // R3 external and slow sources
    ext_per = 3; wr(5'h00, 32'h0000_0017); wait_n(40); look(5'h10, "R3");
    slow_per = 7; wr(5'h00, 32'h0000_0019); wait_n(60); look(5'h10, "R3");
    // R3 unused code 5 freezes the counter
    wr(5'h00, 32'h0000_000B);
    peek(5'h10, "R3", m_cnt); snap = m_cnt;
    wait_n(10); peek(5'h10, "R3", snap);
    wr(5'h00, 32'h0000_0001); wait_n(8); peek(5'h10, "R3", snap);
    // R10 capture enabled and disabled
    wr(5'h08, 100);
    wr(5'h00, 32'h0000_0403); wait_n(5);
    cap_pulse(); look(5'h0C, "R10");
    wait_n(7); cap_pulse(); look(5'h0C, "R10");
    wr(5'h00, 32'h0000_0003); snap = m_cap;
    cap_pulse(); peek(5'h0C, "R10", snap);
    // R12 disable holds counter
    wr(5'h00, 32'h0000_0002);
    peek(5'h10, "R12", m_cnt); snap = m_cnt;
    wait_n(10); peek(5'h10, "R12", snap);
    // R5 prescale lowered below current phase
    wr(5'h00, 32'h0000_0003);
    wr(5'h04, 10); wait_n(5); wr(5'h04, 1); wait_n(20); look(5'h10, "R5");
    // R11 software reset
    wr(5'h04, 0); wr(5'h08, 3);
    wr(5'h00, 32'h0000_0213); wait_n(15);
    @(negedge clk); #2; wr_en = 1'b1; addr = 5'h00; wr_data = 32'h0000_8213;
    @(negedge clk); chk("R11", rd_data, 32'h0000_8000);
    #2; wr_en = 1'b0;
    @(negedge clk); chk("R11", rd_data, 32'h0000_0000);
    chk("R11", 32'(tog_out), 0);
    peek(5'h10, "R11", 0); peek(5'h08, "R11", 0);
    peek(5'h04, "R11", 0); peek(5'h14, "R11", 0);
    finish_run();
  end
endmodule